// File: doc/BRIEF.md
# Clock Ratio Speed-Mode Detector

This block sits in the master-clock domain of an audio converter. It decides at which sampling speed the converter runs: normal, double or quad. A set of clock-configuration inputs, taken in only while the part is powered down, selects one of two paths. The first is a fixed manual setting with a known master-clock multiple of the sample rate. The second is an automatic path that measures the master-clock-to-frame-clock ratio at run time.

On the automatic path, the frame clock is brought into the master-clock domain through a two-flop synchronizer. A counter measures each frame period in master-clock cycles and saturates at 2047. A small state machine with the states S_WAIT, S_FIRST, S_MATCH and S_LOCK maps the measured period onto a speed mode:

- S_WAIT goes to S_FIRST on the first frame edge.
- S_FIRST goes to S_MATCH on a supported period.
- S_MATCH goes to S_LOCK on a repeat of the same period, and stays in S_MATCH on a different supported period.
- S_LOCK stays in S_LOCK on the committed period, and goes to S_MATCH on another supported period.
- Any unsupported period sends the machine to S_FIRST.
- Leaving the automatic path or entering power-down sends the machine to S_WAIT.

Ratios come in two families: powers of two and 1.5 times those. A mode is committed only after two equal, consecutive periods.

Top module: `spdmode_detect`

## Requirements
- R1: In automatic mode, a committed period of 512 or 768 master clocks gives `speed_mode` = 00 (normal), and `mult_fs` equals the measured period.
- R2: In automatic mode, a committed period of 256 or 384 gives `speed_mode` = 01 (double), and `mult_fs` equals the period.
- R3: In automatic mode, a committed period of 128 or 192 gives `speed_mode` = 10 (quad), and `mult_fs` equals the period.
- R4: With `ser_sel` = 1, the automatic path is used only for `cmode_i` = 1, `cks_i` = 11 and `dfs_i` = 01. The combination `cmode_i` = 0, `cks_i` = 11, `dfs_i` = 01 is not automatic and is flagged on `cfg_unsup`.
- R5: With `ser_sel` = 0, the automatic path is used only for `dfs_i[0]` = 1 with `cks_i` = 10. In other cases `dfs_i[0]` = 0 gives normal speed and 1 gives double speed, with the following multiples:
  - `cks_i` = 00: 256 at normal speed only.
  - `cks_i` = 01: 512 or 256.
  - `cks_i` = 10: 384 at normal speed.
  - `cks_i` = 11: 1024 or 512.
- R6: With `ser_sel` = 1 and `cmode_i` = 0, `dfs_i` selects the speed: 00 normal, 01 double, 10 quad. The multiples are:
  - `cks_i` = 00: 256 at normal speed only.
  - `cks_i` = 01: 512, 256 or 128.
  - `cks_i` = 10: 1024, 512 or 256.
- R7: With `ser_sel` = 1 and `cmode_i` = 1, the multiples are:
  - `cks_i` = 00: 384 at normal speed only.
  - `cks_i` = 01: 768, 384 or 192.
  - Any other manual combination, including `dfs_i` = 11, drives `cfg_unsup` = 1, `mode_valid` = 0 and `mult_fs` = 0.
- R8: Configuration inputs are captured only while `pwrdn` = 1. Changes made while running have no effect on any output.
- R9: A mode is committed only after two consecutive frame periods measure the same supported ratio. `mode_valid` stays 0 until the first commit, then stays 1 until power-down.
- R10: A period outside the supported set, including the saturated count 2047, keeps the committed mode and multiple. It sets `ratio_unsup` until the next period completes.
- R11: While `pwrdn` = 1, and after reset, all outputs are 0 and detection restarts from S_WAIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrdn | input | 1 | Power-down; configuration is captured while high |
| frame_clk | input | 1 | Frame (sample-rate) clock, asynchronous |
| ser_sel | input | 1 | 1 = serial-control decode, 0 = parallel-pin decode |
| cmode_i | input | 1 | Clock family select (binary or 1.5x) in serial decode |
| cks_i | input | 2 | Master-clock multiple select |
| dfs_i | input | 2 | Speed select (bit 0 only in parallel decode) |
| speed_mode | output | 2 | 00 normal, 01 double, 10 quad |
| mode_valid | output | 1 | Speed mode and multiple are valid |
| ratio_unsup | output | 1 | Last measured period is not a supported ratio |
| cfg_unsup | output | 1 | Manual configuration combination is not supported |
| mult_fs | output | 11 | Master-clock multiple of the sample rate |

## Verification
A wrong state or a wrong candidate register shows as `mode_valid` rising one frame period too early or too late. A wrong candidate can also show as a mode change after a single odd period, or a missing change after two matching ones. Every such fault reaches the ports within about four master clocks of the frame edge that ends the period. A wrongly captured configuration shows at once on `cfg_unsup`, `speed_mode` and `mult_fs` after power-down is released. The bench therefore checks each frame edge a fixed six cycles later, and checks each manual setting a few cycles after release.

// File: rtl/spdmode_pkg.sv
package spdmode_pkg;

    typedef enum logic [1:0] {
        SPD_NORMAL = 2'b00,
        SPD_DOUBLE = 2'b01,
        SPD_QUAD   = 2'b10
    } spd_e;

    typedef enum logic [1:0] {
        S_WAIT  = 2'b00,
        S_FIRST = 2'b01,
        S_MATCH = 2'b10,
        S_LOCK  = 2'b11
    } det_state_e;

    typedef struct packed {
        logic       ser;
        logic       cmode;
        logic [1:0] cks;
        logic [1:0] dfs;
    } clk_cfg_t;

endpackage

// File: rtl/spdmode_sync.sv
module spdmode_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
        end else begin
            shreg <= {shreg[STAGES-1:0], async_in};
        end
    end

    assign rise = shreg[STAGES-1] & ~shreg[STAGES];
endmodule

// File: rtl/spdmode_period_cnt.sv
module spdmode_period_cnt #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rise,
    output logic [W-1:0] period_len
);
    localparam logic [W-1:0] SAT = {W{1'b1}};

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (rise) begin
            cnt <= W'(1);
        end else if (cnt != SAT) begin
            cnt <= cnt + W'(1);
        end
    end

    assign period_len = cnt;
endmodule

// File: rtl/spdmode_cfg_decode.sv
module spdmode_cfg_decode
    import spdmode_pkg::*;
#(
    parameter int W       = 11,
    parameter int FS_UNIT = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pwrdn,
    input  logic         ser_sel,
    input  logic         cmode_i,
    input  logic [1:0]   cks_i,
    input  logic [1:0]   dfs_i,
    output clk_cfg_t     cfg_q,
    output logic         auto_en,
    output logic         man_ok,
    output spd_e         man_mode,
    output logic [W-1:0] man_mult
);
    localparam logic [W-1:0] M256  = W'(2 * FS_UNIT);
    localparam logic [W-1:0] M384  = W'(3 * FS_UNIT);
    localparam logic [W-1:0] M512  = W'(4 * FS_UNIT);
    localparam logic [W-1:0] M768  = W'(6 * FS_UNIT);
    localparam logic [W-1:0] M1024 = W'(8 * FS_UNIT);

    logic [1:0]   idx;
    logic [W-1:0] norm_mult;
    logic         norm_only;
    logic         spd_bad;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (pwrdn) begin
            cfg_q <= '{ser: ser_sel, cmode: cmode_i, cks: cks_i, dfs: dfs_i};
        end
    end

    always_comb begin
        auto_en   = 1'b0;
        idx       = 2'b00;
        norm_mult = '0;
        norm_only = 1'b0;
        spd_bad   = 1'b0;
        if (cfg_q.ser) begin
            idx     = cfg_q.dfs;
            spd_bad = (cfg_q.dfs == 2'b11);
            auto_en = cfg_q.cmode && (cfg_q.cks == 2'b11) && (cfg_q.dfs == 2'b01);
            unique case ({cfg_q.cmode, cfg_q.cks})
                3'b000: begin norm_mult = M256;  norm_only = 1'b1; end
                3'b001: norm_mult = M512;
                3'b010: norm_mult = M1024;
                3'b100: begin norm_mult = M384;  norm_only = 1'b1; end
                3'b101: norm_mult = M768;
                default: norm_mult = '0;
            endcase
        end else begin
            idx     = {1'b0, cfg_q.dfs[0]};
            auto_en = cfg_q.dfs[0] && (cfg_q.cks == 2'b10);
            unique case (cfg_q.cks)
                2'b00: begin norm_mult = M256; norm_only = 1'b1; end
                2'b01: norm_mult = M512;
                2'b10: begin norm_mult = M384; norm_only = 1'b1; end
                2'b11: norm_mult = M1024;
            endcase
        end
        man_ok   = !auto_en && !spd_bad && (norm_mult != '0) && !(norm_only && (idx != 2'b00));
        man_mode = spd_e'(idx);
        man_mult = norm_mult >> idx;
    end
endmodule

// File: rtl/spdmode_detect.sv
module spdmode_detect
    import spdmode_pkg::*;
#(
    parameter int W           = 11,
    parameter int FS_UNIT     = 128,
    parameter int SYNC_STAGES = 2
) (
    input  logic         mclk,
    input  logic         rst_n,
    input  logic         pwrdn,
    input  logic         frame_clk,
    input  logic         ser_sel,
    input  logic         cmode_i,
    input  logic [1:0]   cks_i,
    input  logic [1:0]   dfs_i,
    output logic [1:0]   speed_mode,
    output logic         mode_valid,
    output logic         ratio_unsup,
    output logic         cfg_unsup,
    output logic [W-1:0] mult_fs
);
    localparam logic [W-1:0] R_QB = W'(FS_UNIT);
    localparam logic [W-1:0] R_QH = W'(FS_UNIT * 3 / 2);
    localparam logic [W-1:0] R_DB = W'(FS_UNIT * 2);
    localparam logic [W-1:0] R_DH = W'(FS_UNIT * 3);
    localparam logic [W-1:0] R_NB = W'(FS_UNIT * 4);
    localparam logic [W-1:0] R_NH = W'(FS_UNIT * 6);

    logic         rise;
    logic [W-1:0] period_len;
    clk_cfg_t     cfg_q;
    logic         auto_en;
    logic         man_ok;
    spd_e         man_mode;
    logic [W-1:0] man_mult;

    det_state_e   state, state_nxt;
    logic         run;
    logic         ratio_ok;
    spd_e         ratio_mode;
    logic [W-1:0] cand_len;
    logic [W-1:0] commit_len;
    spd_e         commit_mode;
    logic         have_commit;
    logic         unsup_r;
    logic         period_end;

    spdmode_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (mclk),
        .rst_n    (rst_n),
        .async_in (frame_clk),
        .rise     (rise)
    );

    spdmode_period_cnt #(.W(W)) u_cnt (
        .clk        (mclk),
        .rst_n      (rst_n),
        .rise       (rise),
        .period_len (period_len)
    );

    spdmode_cfg_decode #(.W(W), .FS_UNIT(FS_UNIT)) u_cfg (
        .clk      (mclk),
        .rst_n    (rst_n),
        .pwrdn    (pwrdn),
        .ser_sel  (ser_sel),
        .cmode_i  (cmode_i),
        .cks_i    (cks_i),
        .dfs_i    (dfs_i),
        .cfg_q    (cfg_q),
        .auto_en  (auto_en),
        .man_ok   (man_ok),
        .man_mode (man_mode),
        .man_mult (man_mult)
    );

    assign run        = auto_en && !pwrdn;
    assign period_end = run && rise && (state != S_WAIT);

    // Ratio classification: binary and 1.5x families per speed.
    always_comb begin
        ratio_ok   = 1'b1;
        ratio_mode = SPD_NORMAL;
        if (period_len == R_NB || period_len == R_NH) begin
            ratio_mode = SPD_NORMAL;
        end else if (period_len == R_DB || period_len == R_DH) begin
            ratio_mode = SPD_DOUBLE;
        end else if (period_len == R_QB || period_len == R_QH) begin
            ratio_mode = SPD_QUAD;
        end else begin
            ratio_ok = 1'b0;
        end
    end

    // State register.
    always_ff @(posedge mclk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_WAIT;
        end else begin
            state <= state_nxt;
        end
    end

    // Next state.
    always_comb begin
        state_nxt = state;
        unique case (state)
            S_WAIT: begin
                if (rise) state_nxt = S_FIRST;
            end
            S_FIRST: begin
                if (rise && ratio_ok) state_nxt = S_MATCH;
            end
            S_MATCH: begin
                if (rise) begin
                    if (!ratio_ok)                  state_nxt = S_FIRST;
                    else if (period_len == cand_len) state_nxt = S_LOCK;
                end
            end
            S_LOCK: begin
                if (rise) begin
                    if (!ratio_ok)                     state_nxt = S_FIRST;
                    else if (period_len != commit_len) state_nxt = S_MATCH;
                end
            end
        endcase
        if (!run) state_nxt = S_WAIT;
    end

    // Candidate and committed ratio.
    always_ff @(posedge mclk or negedge rst_n) begin
        if (!rst_n) begin
            cand_len    <= '0;
            commit_len  <= '0;
            commit_mode <= SPD_NORMAL;
            have_commit <= 1'b0;
            unsup_r     <= 1'b0;
        end else if (!run) begin
            cand_len    <= '0;
            commit_len  <= '0;
            commit_mode <= SPD_NORMAL;
            have_commit <= 1'b0;
            unsup_r     <= 1'b0;
        end else if (period_end) begin
            unsup_r <= !ratio_ok;
            if (ratio_ok) begin
                cand_len <= period_len;
                if (state == S_MATCH && period_len == cand_len) begin
                    commit_len  <= period_len;
                    commit_mode <= ratio_mode;
                    have_commit <= 1'b1;
                end
            end
        end
    end

    // Outputs.
    always_ff @(posedge mclk or negedge rst_n) begin
        if (!rst_n) begin
            speed_mode  <= SPD_NORMAL;
            mode_valid  <= 1'b0;
            ratio_unsup <= 1'b0;
            cfg_unsup   <= 1'b0;
            mult_fs     <= '0;
        end else if (pwrdn) begin
            speed_mode  <= SPD_NORMAL;
            mode_valid  <= 1'b0;
            ratio_unsup <= 1'b0;
            cfg_unsup   <= 1'b0;
            mult_fs     <= '0;
        end else if (auto_en) begin
            speed_mode  <= commit_mode;
            mode_valid  <= have_commit;
            ratio_unsup <= unsup_r;
            cfg_unsup   <= 1'b0;
            mult_fs     <= commit_len;
        end else if (man_ok) begin
            speed_mode  <= man_mode;
            mode_valid  <= 1'b1;
            ratio_unsup <= 1'b0;
            cfg_unsup   <= 1'b0;
            mult_fs     <= man_mult;
        end else begin
            speed_mode  <= SPD_NORMAL;
            mode_valid  <= 1'b0;
            ratio_unsup <= 1'b0;
            cfg_unsup   <= 1'b1;
            mult_fs     <= '0;
        end
    end
endmodule

// File: rtl/spdmode_detect_chk.sv
module spdmode_detect_chk
    import spdmode_pkg::*;
#(
    parameter int W       = 11,
    parameter int FS_UNIT = 128
) (
    input logic         mclk,
    input logic         rst_n,
    input logic         pwrdn,
    input logic         auto_en,
    input clk_cfg_t     cfg_q,
    input logic [1:0]   speed_mode,
    input logic         mode_valid,
    input logic         ratio_unsup,
    input logic [W-1:0] mult_fs
);
    localparam int NB = FS_UNIT * 4;
    localparam int NH = FS_UNIT * 6;
    localparam int DB = FS_UNIT * 2;
    localparam int DH = FS_UNIT * 3;
    localparam int QB = FS_UNIT;
    localparam int QH = FS_UNIT * 3 / 2;

    AST_AUTO_NORMAL_MULT: assert property (@(posedge mclk) disable iff (!rst_n)
        (auto_en && mode_valid && speed_mode == 2'b00) |-> (int'(mult_fs) == NB || int'(mult_fs) == NH)); // R1

    AST_AUTO_DOUBLE_MULT: assert property (@(posedge mclk) disable iff (!rst_n)
        (auto_en && mode_valid && speed_mode == 2'b01) |-> (int'(mult_fs) == DB || int'(mult_fs) == DH)); // R2

    AST_AUTO_QUAD_MULT: assert property (@(posedge mclk) disable iff (!rst_n)
        (auto_en && mode_valid && speed_mode == 2'b10) |-> (int'(mult_fs) == QB || int'(mult_fs) == QH)); // R3

    AST_CFG_FROZEN: assert property (@(posedge mclk) disable iff (!rst_n)
        !pwrdn |=> $stable(cfg_q)); // R8

    AST_VALID_STICKY: assert property (@(posedge mclk) disable iff (!rst_n)
        (auto_en && mode_valid && !pwrdn) |=> mode_valid); // R9

    AST_UNSUP_KEEPS_MODE: assert property (@(posedge mclk) disable iff (!rst_n)
        (ratio_unsup && $past(mode_valid) && mode_valid) |-> ($stable(speed_mode) && $stable(mult_fs))); // R10

    AST_PDN_QUIET: assert property (@(posedge mclk) disable iff (!rst_n)
        pwrdn |=> (!mode_valid && !ratio_unsup)); // R11
endmodule

bind spdmode_detect spdmode_detect_chk #(.W(W), .FS_UNIT(FS_UNIT)) u_chk (
    .mclk        (mclk),
    .rst_n       (rst_n),
    .pwrdn       (pwrdn),
    .auto_en     (auto_en),
    .cfg_q       (cfg_q),
    .speed_mode  (speed_mode),
    .mode_valid  (mode_valid),
    .ratio_unsup (ratio_unsup),
    .mult_fs     (mult_fs)
);

// File: tb/spdmode_detect_tb.sv
`timescale 1ns/1ps
module spdmode_detect_tb;
    localparam int W = 11;

    logic         mclk = 1'b0;
    logic         rst_n, pwrdn, frame_clk, ser_sel, cmode_i;
    logic [1:0]   cks_i, dfs_i;
    logic [1:0]   speed_mode;
    logic         mode_valid, ratio_unsup, cfg_unsup;
    logic [W-1:0] mult_fs;

    always #2.5 mclk = ~mclk;

    spdmode_detect u_dut (
        .mclk(mclk), .rst_n(rst_n), .pwrdn(pwrdn), .frame_clk(frame_clk),
        .ser_sel(ser_sel), .cmode_i(cmode_i), .cks_i(cks_i), .dfs_i(dfs_i),
        .speed_mode(speed_mode), .mode_valid(mode_valid), .ratio_unsup(ratio_unsup),
        .cfg_unsup(cfg_unsup), .mult_fs(mult_fs)
    );

    typedef struct {
        logic [1:0]  mode;
        logic        valid;
        logic        unsup;
        logic [10:0] mult;
        logic        bad;
        string       req;
        int          due;
    } exp_t;

    exp_t  sb_q[$];
    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string cur_req = "R9";

    // reference model of the automatic path
    bit m_first, m_cand_v, m_have, m_unsup;
    int m_cand, m_commit, m_len;

    always @(posedge mclk) cyc <= cyc + 1;

    function automatic bit is_sup(int r);
        return r == 128 || r == 192 || r == 256 || r == 384 || r == 512 || r == 768;
    endfunction

    function automatic logic [1:0] spd_of(int r);
        if (r >= 512) return 2'b00;
        if (r >= 256) return 2'b01;
        return 2'b10;
    endfunction

    task automatic push(logic [1:0] md, logic v, logic u, int mu, logic b, string rq, int dly);
        exp_t e;
        e.mode = md; e.valid = v; e.unsup = u; e.mult = 11'(mu); e.bad = b;
        e.req = rq; e.due = cyc + dly;
        sb_q.push_back(e);
    endtask

    // monitor: pops and compares each expected item when due
    always @(negedge mclk) begin
        while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (speed_mode !== e.mode || mode_valid !== e.valid || ratio_unsup !== e.unsup ||
                mult_fs !== e.mult || cfg_unsup !== e.bad) begin
                errors++;
                $display("FAIL %s: actual mode=%b valid=%b unsup=%b mult=%0d bad=%b expected mode=%b valid=%b unsup=%b mult=%0d bad=%b",
                         e.req, speed_mode, mode_valid, ratio_unsup, mult_fs, cfg_unsup,
                         e.mode, e.valid, e.unsup, e.mult, e.bad);
            end
        end
    end

    task automatic model_reset();
        m_first = 0; m_cand_v = 0; m_have = 0; m_unsup = 0;
        m_cand = 0; m_commit = 0; m_len = 0;
    endtask

    task automatic rise_and_expect();
        frame_clk = 1'b1;
        if (m_first) begin
            int r;
            r = (m_len > 2047) ? 2047 : m_len;
            if (is_sup(r)) begin
                m_unsup = 0;
                if (m_cand_v && m_cand == r) begin
                    m_have = 1; m_commit = r;
                end
                m_cand = r; m_cand_v = 1;
            end else begin
                m_unsup = 1; m_cand_v = 0;
            end
        end
        m_first = 1;
        push(m_have ? spd_of(m_commit) : 2'b00, m_have, m_unsup, m_have ? m_commit : 0, 1'b0, cur_req, 6);
    endtask

    task automatic period(int n);
        rise_and_expect();
        repeat (n / 2) @(negedge mclk);
        frame_clk = 1'b0;
        repeat (n - n / 2) @(negedge mclk);
        m_len = n;
    endtask

    task automatic tail();
        rise_and_expect();
        repeat (4) @(negedge mclk);
        frame_clk = 1'b0;
        repeat (10) @(negedge mclk);
    endtask

    task automatic set_cfg(logic s, logic c, logic [1:0] k, logic [1:0] d);
        pwrdn = 1'b1; frame_clk = 1'b0;
        ser_sel = s; cmode_i = c; cks_i = k; dfs_i = d;
        repeat (3) @(negedge mclk);
        push(2'b00, 1'b0, 1'b0, 0, 1'b0, "R11", 0);   // R11: quiet in power-down
        @(negedge mclk);
        pwrdn = 1'b0;
        model_reset();
        repeat (3) @(negedge mclk);
    endtask

    task automatic chk_now(logic [1:0] md, logic v, int mu, logic b, string rq);
        push(md, v, 1'b0, mu, b, rq, 1);
        repeat (2) @(negedge mclk);
    endtask

    task automatic man(logic s, logic c, logic [1:0] k, logic [1:0] d,
                       logic [1:0] md, logic v, int mu, string rq);
        set_cfg(s, c, k, d);
        chk_now(md, v, mu, !v, rq);
    endtask

    initial begin
        repeat (180000) @(posedge mclk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; pwrdn = 1'b1; frame_clk = 1'b0;
        ser_sel = 1'b1; cmode_i = 1'b1; cks_i = 2'b11; dfs_i = 2'b01;
        model_reset();
        repeat (4) @(negedge mclk);
        chk_now(2'b00, 1'b0, 0, 1'b0, "R11");      // reset state
        rst_n = 1'b1;

        // serial automatic path (R4)
        set_cfg(1'b1, 1'b1, 2'b11, 2'b01);
        cur_req = "R9";  period(512); period(512);
        cur_req = "R1";  period(512); period(768); period(768);
        cur_req = "R2";  period(256); period(256); period(384); period(384);
        cmode_i = 1'b0; cks_i = 2'b00;              // R8: ignored while running
        cur_req = "R3";  period(128); period(128); period(192); period(192);
        cur_req = "R10"; period(300); period(300); period(2100); period(256);
        cur_req = "R9";  period(128); period(256); period(128); period(128);
        tail();

        // serial manual, binary family (R6)
        man(1'b1, 1'b0, 2'b00, 2'b00, 2'b00, 1'b1, 256,  "R6");
        man(1'b1, 1'b0, 2'b00, 2'b01, 2'b00, 1'b0, 0,    "R6");
        man(1'b1, 1'b0, 2'b01, 2'b10, 2'b10, 1'b1, 128,  "R6");
        man(1'b1, 1'b0, 2'b10, 2'b01, 2'b01, 1'b1, 512,  "R6");
        man(1'b1, 1'b0, 2'b10, 2'b10, 2'b10, 1'b1, 256,  "R6");
        man(1'b1, 1'b0, 2'b11, 2'b01, 2'b00, 1'b0, 0,    "R4");
        // serial manual, 1.5x family (R7)
        man(1'b1, 1'b1, 2'b00, 2'b00, 2'b00, 1'b1, 384,  "R7");
        man(1'b1, 1'b1, 2'b01, 2'b01, 2'b01, 1'b1, 384,  "R7");
        man(1'b1, 1'b1, 2'b01, 2'b10, 2'b10, 1'b1, 192,  "R7");
        man(1'b1, 1'b1, 2'b10, 2'b00, 2'b00, 1'b0, 0,    "R7");
        man(1'b1, 1'b1, 2'b01, 2'b11, 2'b00, 1'b0, 0,    "R7");
        man(1'b1, 1'b1, 2'b11, 2'b00, 2'b00, 1'b0, 0,    "R7");
        // parallel manual (R5)
        man(1'b0, 1'b0, 2'b00, 2'b00, 2'b00, 1'b1, 256,  "R5");
        man(1'b0, 1'b0, 2'b00, 2'b01, 2'b00, 1'b0, 0,    "R5");
        man(1'b0, 1'b0, 2'b01, 2'b01, 2'b01, 1'b1, 256,  "R5");
        man(1'b0, 1'b0, 2'b10, 2'b00, 2'b00, 1'b1, 384,  "R5");
        man(1'b0, 1'b0, 2'b11, 2'b00, 2'b00, 1'b1, 1024, "R5");
        man(1'b0, 1'b1, 2'b11, 2'b01, 2'b01, 1'b1, 512,  "R5");

        // parallel automatic path (R5)
        set_cfg(1'b0, 1'b0, 2'b10, 2'b01);
        cur_req = "R5"; period(192); period(192); period(192);
        tail();

        // running change ignored in manual mode (R8)
        man(1'b1, 1'b0, 2'b01, 2'b00, 2'b00, 1'b1, 512, "R8");
        ser_sel = 1'b0; cks_i = 2'b10; dfs_i = 2'b10; cmode_i = 1'b1;
        repeat (5) @(negedge mclk);
        chk_now(2'b00, 1'b1, 512, 1'b0, "R8");

        repeat (10) @(negedge mclk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule